// File: doc/BRIEF.md
# Automatic Gain Control Step Counter

This block is the digital half of an automatic gain control loop. An external level detector and comparator report, once per loop update, whether the controlled signal sits above or below its reference level. The block holds an attenuation code that drives a logarithmic variable-gain element. On each update tick it moves the code one step, in the direction that pushes the output level back toward the reference. A higher code means more attenuation.

The count saturates at zero and at the highest valid attenuation code, 239 by default. It therefore never wraps, and it never enters the codes above that limit, which mute the element. A deadband input lets the surrounding loop freeze the code while the level is within tolerance. When the input signal lies outside the range the element can correct, the code parks at an end stop and stays there. The update tick sets the loop time constant.

Top module: `agc_gain_stepper`

## Requirements
- R1: While `rst` is high at a rising clock edge, `gain_code` takes `RESET_CODE` (0 by default) after that edge.
- R2: At an edge where `step_tick`=1, `in_window`=0, `level_high`=1 and `gain_code` is below `CODE_MAX`, `gain_code` rises by exactly one.
- R3: At an edge where `step_tick`=1, `in_window`=0, `level_high`=0 and `gain_code` is above 0, `gain_code` falls by exactly one.
- R4: At an edge where `step_tick`=0, `gain_code` keeps its value, whatever `level_high` and `in_window` are.
- R5: At an edge where `in_window`=1, `gain_code` keeps its value, even with `step_tick`=1.
- R6: With `gain_code` equal to `CODE_MAX` (239 by default), a tick with `level_high`=1 leaves it at `CODE_MAX`. It does not move into the mute codes 240 to 255, and it does not wrap to 0.
- R7: With `gain_code` equal to 0, a tick with `level_high`=0 leaves it at 0 and does not wrap to the top code.
- R8: `gain_code` never exceeds `CODE_MAX` in any cycle.
- R9: In a closed loop, the code converges on the level where the comparator changes state. Without the deadband it dithers between the two adjacent codes at that level. With the deadband it stops at the first code inside the tolerance band. If the input lies outside the range the element can correct, the code rests at the end stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_tick | input | 1 | Loop update strobe; the code moves only at edges where it is high |
| level_high | input | 1 | Comparator result: 1 = output level above reference, 0 = below |
| in_window | input | 1 | Deadband flag: 1 = level within tolerance, hold the code |
| gain_code | output | CODE_W | Attenuation code, 0 to CODE_MAX |

## Verification
Open-loop patterns come first. Runs of ticks in one direction show that stepping is by one code. Ticks mixed with idle cycles and with deadband cycles tell the hold conditions apart from a step. Long runs of ticks pressed against each end stop separate saturation from wraparound and from entry into the mute codes. Closed-loop runs then use a modelled signal level, where the output level equals the input level minus the code. One input level lies inside the correctable range and one lies beyond each end. These runs show dithering convergence without the deadband, a clean stop with it, and stable parking at both end stops.

// File: rtl/agc_pkg.sv
package agc_pkg;

    // Direction of one code step, as requested and as granted
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

    // Step request formed from the loop inputs on an update edge
    typedef struct packed {
        logic      fire;
        step_dir_e dir;
    } step_req_t;

endpackage

// File: rtl/agc_step_decide.sv
module agc_step_decide
    import agc_pkg::*;
(
    input  logic      step_tick,
    input  logic      level_high,
    input  logic      in_window,
    output step_req_t req
);

    // Above the reference -> more attenuation (negative feedback on gain)
    always_comb begin
        req.fire = step_tick && !in_window;
        req.dir  = level_high ? STEP_UP : STEP_DOWN;
    end

endmodule

// File: rtl/agc_end_stop.sv
module agc_end_stop
    import agc_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int CODE_MAX = 239
) (
    input  logic [CODE_W-1:0] code,
    input  step_req_t         req,
    output step_dir_e         grant
);

    localparam logic [CODE_W-1:0] TOP_CODE = CODE_MAX[CODE_W-1:0];

    logic at_top;
    logic at_floor;

    generate
        if (CODE_MAX == (1 << CODE_W) - 1) begin : g_full_range
            assign at_top = &code;
        end else begin : g_part_range
            assign at_top = (code >= TOP_CODE);
        end
    endgenerate

    assign at_floor = (code == '0);

    always_comb begin
        grant = STEP_HOLD;
        if (req.fire) begin
            unique case (req.dir)
                STEP_UP:   grant = at_top   ? STEP_HOLD : STEP_UP;
                STEP_DOWN: grant = at_floor ? STEP_HOLD : STEP_DOWN;
                default:   grant = STEP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/agc_code_reg.sv
module agc_code_reg
    import agc_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int RESET_CODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  step_dir_e         grant,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] INIT_CODE = RESET_CODE[CODE_W-1:0];
    localparam logic [CODE_W-1:0] ONE_STEP  = CODE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= INIT_CODE;
        end else begin
            case (grant)
                STEP_UP:   code <= code + ONE_STEP;
                STEP_DOWN: code <= code - ONE_STEP;
                default:   code <= code;
            endcase
        end
    end

endmodule

// File: rtl/agc_gain_stepper.sv
module agc_gain_stepper
    import agc_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int CODE_MAX   = 239,
    parameter int RESET_CODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_tick,
    input  logic              level_high,
    input  logic              in_window,
    output logic [CODE_W-1:0] gain_code
);

    step_req_t req;
    step_dir_e grant;

    agc_step_decide u_decide (
        .step_tick  (step_tick),
        .level_high (level_high),
        .in_window  (in_window),
        .req        (req)
    );

    agc_end_stop #(
        .CODE_W   (CODE_W),
        .CODE_MAX (CODE_MAX)
    ) u_end_stop (
        .code  (gain_code),
        .req   (req),
        .grant (grant)
    );

    agc_code_reg #(
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE)
    ) u_code_reg (
        .clk   (clk),
        .rst   (rst),
        .grant (grant),
        .code  (gain_code)
    );

endmodule

// File: rtl/agc_gain_stepper_chk.sv
module agc_gain_stepper_chk #(
    parameter int CODE_W     = 8,
    parameter int CODE_MAX   = 239,
    parameter int RESET_CODE = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              step_tick,
    input logic              level_high,
    input logic              in_window,
    input logic [CODE_W-1:0] gain_code
);

    localparam logic [CODE_W-1:0] TOP_CODE  = CODE_MAX[CODE_W-1:0];
    localparam logic [CODE_W-1:0] INIT_CODE = RESET_CODE[CODE_W-1:0];
    localparam logic [CODE_W-1:0] ONE_STEP  = CODE_W'(1);

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> gain_code == INIT_CODE);

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        step_tick && !in_window && level_high && gain_code < TOP_CODE
        |=> gain_code == $past(gain_code) + ONE_STEP);

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        step_tick && !in_window && !level_high && gain_code != '0
        |=> gain_code == $past(gain_code) - ONE_STEP);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !step_tick |=> $stable(gain_code));

    assert_window_hold_R5: assert property (@(posedge clk) disable iff (rst)
        in_window |=> $stable(gain_code));

    assert_top_stop_R6: assert property (@(posedge clk) disable iff (rst)
        step_tick && level_high && gain_code == TOP_CODE |=> gain_code == TOP_CODE);

    assert_floor_stop_R7: assert property (@(posedge clk) disable iff (rst)
        step_tick && !level_high && gain_code == '0 |=> gain_code == '0);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        gain_code <= TOP_CODE);

endmodule

bind agc_gain_stepper agc_gain_stepper_chk #(
    .CODE_W     (CODE_W),
    .CODE_MAX   (CODE_MAX),
    .RESET_CODE (RESET_CODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_tick  (step_tick),
    .level_high (level_high),
    .in_window  (in_window),
    .gain_code  (gain_code)
);

// File: tb/tb_agc_gain_stepper.sv
`timescale 1ns/1ps
module tb_agc_gain_stepper;

    localparam int CODE_W   = 8;
    localparam int CODE_MAX = 239;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              step_tick = 1'b0;
    logic              level_high = 1'b0;
    logic              in_window = 1'b0;
    logic [CODE_W-1:0] gain_code;

    int checks = 0;
    int errors = 0;
    int model_code = 0;
    bit finished = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    agc_gain_stepper #(
        .CODE_W     (CODE_W),
        .CODE_MAX   (CODE_MAX),
        .RESET_CODE (0)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .step_tick  (step_tick),
        .level_high (level_high),
        .in_window  (in_window),
        .gain_code  (gain_code)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s gain_code=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    // Driver: apply one cycle of inputs, predict the code after the next edge
    task automatic drive(input bit tick, input bit high, input bit win, input string tag);
        @(negedge clk);
        step_tick  = tick;
        level_high = high;
        in_window  = win;
        if (tick && !win) begin
            if (high) model_code = (model_code < CODE_MAX) ? model_code + 1 : CODE_MAX;
            else      model_code = (model_code > 0) ? model_code - 1 : 0;
        end
        exp_q.push_back(model_code);
        tag_q.push_back(tag);
    endtask

    // Monitor: after each edge, compare with the oldest prediction
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() != 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(gain_code), e);
            if (int'(gain_code) > CODE_MAX)
                check("R8", int'(gain_code), CODE_MAX);
        end
    end

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
        step_tick = 1'b0;
    endtask

    // Closed loop: output level = in_level - code, compared with ref_level
    task automatic closed_loop(input int in_level, input int ref_level,
                               input bit use_window, input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            int  err;
            bit  hi, win;
            err = in_level - model_code - ref_level;
            hi  = (err > 0);
            win = use_window && (err >= -1) && (err <= 1);
            drive((i % 2) == 0, hi, win, tag);
        end
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", int'(gain_code), 0);

        // R7: floor end stop
        drive(1, 0, 0, "R7");
        drive(1, 0, 0, "R7");
        // R4: no tick, other inputs toggling
        drive(0, 1, 0, "R4");
        drive(0, 0, 1, "R4");
        // R2: single steps up
        for (int i = 0; i < 5; i++) drive(1, 1, 0, "R2");
        // R5: deadband holds on tick both directions
        drive(1, 1, 1, "R5");
        drive(1, 0, 1, "R5");
        // R3: single steps down
        drive(1, 0, 0, "R3");
        drive(1, 0, 0, "R3");
        // R4 with nonzero code
        drive(0, 1, 0, "R4");
        drive(0, 0, 0, "R4");
        // R6: climb and press against the top stop
        for (int i = 0; i < 260; i++) drive(1, 1, 0, "R6");
        drain();
        check("R6", int'(gain_code), CODE_MAX);
        // R3 leaving the top stop
        drive(1, 0, 0, "R3");
        drain();
        check("R3", int'(gain_code), CODE_MAX - 1);

        // R9: input beyond correctable range parks at the top stop
        closed_loop(300, 40, 0, 40, "R9");
        check("R9", int'(gain_code), CODE_MAX);
        // R9 with deadband, approaching from above: stops at 111
        closed_loop(150, 40, 1, 400, "R9");
        check("R9", int'(gain_code), 111);
        // R9 without deadband: dithers between 109 and 110
        closed_loop(150, 40, 0, 60, "R9");
        checks++;
        if (gain_code != 8'd109 && gain_code != 8'd110) begin
            errors++;
            $display("FAIL R9 gain_code=%0d expected=109 or 110", gain_code);
        end
        // R9/R7: input below reference parks at the floor stop
        closed_loop(20, 40, 0, 300, "R9");
        check("R7", int'(gain_code), 0);

        // R1: reset from a nonzero code
        drive(1, 1, 0, "R2");
        drive(1, 1, 0, "R2");
        drain();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", int'(gain_code), 0);
        rst = 1'b0;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog gain_code=%0d expected=run complete", gain_code);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule